// File: doc/BRIEF.md
# Load-Miss Register Readiness Scoreboard

This block keeps one readiness flag per architectural register so that a load missing in the L1 cache does not freeze the execute pipeline. When a miss notice arrives, the block marks the load's destination register as waiting. The execute stages keep running. Only a bundle in decode that touches a waiting register holds the front end (prefetch, fetch and both decode stages). While the front end holds, a bubble enters the first execute stage.

When the memory side returns the missing data, the block passes it to a late-writeback port that targets the register file. The register becomes ready in the same cycle. A decode bundle that reads the returned register in that cycle is told to take the returned value directly, so the return costs no extra stall cycle.

At most a fixed number of misses may be outstanding. Once that many registers are waiting, every valid decode bundle is held until one of them completes. Register ID 0 is the hard-wired zero register: it never waits and never stalls.

Top module: `lms_scoreboard`

## Requirements
- R1: After reset no register is waiting: `fe_stall`, `ex1_nop`, `byp_rs`, `byp_rt` and `wb_valid` are all low.
- R2: A miss notice (`miss_valid` high) with a nonzero `miss_tag` makes that register waiting from the next cycle on. The miss itself raises no stall in the cycle it arrives.
- R3: With `dec_valid` high, `fe_stall` is high in the same cycle if `dec_rs` or `dec_rt` names a waiting register that is not being returned in that cycle.
- R4: With `dec_valid` high, `fe_stall` is also high if `dec_rd` names a waiting register that is not being returned in that cycle.
- R5: Register ID 0 never causes a stall as `dec_rs`, `dec_rt` or `dec_rd`. A miss notice for ID 0 is dropped: it creates no waiting register and does not count toward the limit.
- R6: If a return (`ret_valid`, `ret_tag`) names a waiting register in the same cycle that decode reads it, that operand raises no stall. `byp_rs` or `byp_rt` goes high for each source operand that names the returned register.
- R7: A return for a waiting register raises `wb_valid` in the same cycle, with `wb_tag` = `ret_tag` and `wb_data` = `ret_data`. The register is ready from the next cycle on. A return for a register that is not waiting produces no writeback and changes nothing.
- R8: While 4 (`MAX_OUTST`) or more registers are waiting, `fe_stall` is high for every valid decode bundle, whatever registers it names.
- R9: `ex1_nop` is high exactly in the cycle after a cycle in which `fe_stall` was high.
- R10: A miss and a return naming the same waiting register in the same cycle leave that register waiting. The writeback still occurs.
- R11: With `dec_valid` low, `fe_stall`, `byp_rs` and `byp_rt` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load missed in L1 this cycle |
| miss_tag | input | 6 | Destination register of the missed load |
| ret_valid | input | 1 | Missed load data returns this cycle |
| ret_tag | input | 6 | Register the returned data belongs to |
| ret_data | input | 64 | Returned load data |
| dec_valid | input | 1 | A bundle occupies the decode stage |
| dec_rs | input | 6 | First source register of the decode bundle |
| dec_rt | input | 6 | Second source register of the decode bundle |
| dec_rd | input | 6 | Destination register of the decode bundle |
| fe_stall | output | 1 | Hold prefetch, fetch and both decode stages |
| ex1_nop | output | 1 | Insert a bubble into the first execute stage |
| byp_rs | output | 1 | First source takes `ret_data` this cycle |
| byp_rt | output | 1 | Second source takes `ret_data` this cycle |
| wb_valid | output | 1 | Late register-file write enable |
| wb_tag | output | 6 | Late write register ID |
| wb_data | output | 64 | Late write data |

## Verification
A waiting flag that is wrongly lost shows up as a missing `fe_stall` the next time decode names that register. A flag that is wrongly left set shows up as a spurious stall, or as a missing writeback for a later return. A drift in the outstanding-miss count shows up as a stall on unrelated bundles, or as a missing stall once four registers wait. Every one of these faults is visible at the ports within one cycle of the decode bundle or return that touches the affected register, so the bench compares every port against a reference model in every cycle.

// File: rtl/lms_pkg.sv
package lms_pkg;
    // operand slots examined for each decode bundle
    typedef enum logic [1:0] {
        SLOT_RS = 2'd0,
        SLOT_RT = 2'd1,
        SLOT_RD = 2'd2
    } slot_e;

    localparam int NUM_SLOTS = 3;
endpackage

// File: rtl/lms_slot_probe.sv
module lms_slot_probe #(
    parameter int NUM_REGS = 64,
    parameter int ID_W     = 6,
    parameter int ZERO_ID  = 0
) (
    input  logic                use_i,
    input  logic [ID_W-1:0]     id_i,
    input  logic [NUM_REGS-1:0] pending_i,
    input  logic                ret_valid_i,
    input  logic [ID_W-1:0]     ret_tag_i,
    output logic                pend_o,
    output logic                ret_hit_o
);
    always_comb begin
        pend_o    = use_i && (id_i != ID_W'(ZERO_ID)) && pending_i[id_i];
        ret_hit_o = ret_valid_i && (ret_tag_i == id_i);
    end
endmodule

// File: rtl/lms_track.sv
module lms_track #(
    parameter int NUM_REGS = 64,
    parameter int ID_W     = 6,
    parameter int CNT_W    = 7,
    parameter int ZERO_ID  = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                miss_valid_i,
    input  logic [ID_W-1:0]     miss_tag_i,
    input  logic                ret_valid_i,
    input  logic [ID_W-1:0]     ret_tag_i,
    input  logic                stall_i,
    output logic [NUM_REGS-1:0] pending_o,
    output logic [CNT_W-1:0]    count_o,
    output logic                nop_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0] pending;
        logic [CNT_W-1:0]    count;
        logic                nop;
    } track_t;

    track_t st_d, st_q;
    logic   miss_ok, miss_new, ret_clr;

    always_comb begin
        st_d     = st_q;
        miss_ok  = miss_valid_i && (miss_tag_i != ID_W'(ZERO_ID));
        miss_new = miss_ok && !st_q.pending[miss_tag_i];
        ret_clr  = ret_valid_i && st_q.pending[ret_tag_i]
                   && !(miss_ok && (miss_tag_i == ret_tag_i));
        if (ret_clr) begin
            st_d.pending[ret_tag_i] = 1'b0;
        end
        if (miss_ok) begin
            st_d.pending[miss_tag_i] = 1'b1;
        end
        st_d.count = st_q.count + CNT_W'(miss_new) - CNT_W'(ret_clr);
        st_d.nop   = stall_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o = st_q.pending;
    assign count_o   = st_q.count;
    assign nop_o     = st_q.nop;
endmodule

// File: rtl/lms_scoreboard.sv
module lms_scoreboard #(
    parameter int NUM_REGS  = 64,
    parameter int DATA_W    = 64,
    parameter int MAX_OUTST = 4,
    parameter int ZERO_ID   = 0,
    localparam int ID_W     = $clog2(NUM_REGS),
    localparam int CNT_W    = $clog2(NUM_REGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ID_W-1:0]   miss_tag,
    input  logic              ret_valid,
    input  logic [ID_W-1:0]   ret_tag,
    input  logic [DATA_W-1:0] ret_data,
    input  logic              dec_valid,
    input  logic [ID_W-1:0]   dec_rs,
    input  logic [ID_W-1:0]   dec_rt,
    input  logic [ID_W-1:0]   dec_rd,
    output logic              fe_stall,
    output logic              ex1_nop,
    output logic              byp_rs,
    output logic              byp_rt,
    output logic              wb_valid,
    output logic [ID_W-1:0]   wb_tag,
    output logic [DATA_W-1:0] wb_data
);
    import lms_pkg::*;

    logic [NUM_REGS-1:0]  pending_q;
    logic [CNT_W-1:0]     count_q;
    logic [ID_W-1:0]      slot_id  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_pend;
    logic [NUM_SLOTS-1:0] slot_hit;
    logic [NUM_SLOTS-1:0] slot_wait;
    logic                 limit_hit;

    assign slot_id[SLOT_RS] = dec_rs;
    assign slot_id[SLOT_RT] = dec_rt;
    assign slot_id[SLOT_RD] = dec_rd;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        lms_slot_probe #(
            .NUM_REGS (NUM_REGS),
            .ID_W     (ID_W),
            .ZERO_ID  (ZERO_ID)
        ) u_probe (
            .use_i       (dec_valid),
            .id_i        (slot_id[g]),
            .pending_i   (pending_q),
            .ret_valid_i (ret_valid),
            .ret_tag_i   (ret_tag),
            .pend_o      (slot_pend[g]),
            .ret_hit_o   (slot_hit[g])
        );
        assign slot_wait[g] = slot_pend[g] && !slot_hit[g];
    end

    always_comb begin
        limit_hit = count_q >= CNT_W'(MAX_OUTST);
        fe_stall  = dec_valid && ((|slot_wait) || limit_hit);
        byp_rs    = slot_pend[SLOT_RS] && slot_hit[SLOT_RS];
        byp_rt    = slot_pend[SLOT_RT] && slot_hit[SLOT_RT];
        wb_valid  = ret_valid && pending_q[ret_tag];
        wb_tag    = ret_tag;
        wb_data   = ret_data;
    end

    lms_track #(
        .NUM_REGS (NUM_REGS),
        .ID_W     (ID_W),
        .CNT_W    (CNT_W),
        .ZERO_ID  (ZERO_ID)
    ) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_valid_i (miss_valid),
        .miss_tag_i   (miss_tag),
        .ret_valid_i  (ret_valid),
        .ret_tag_i    (ret_tag),
        .stall_i      (fe_stall),
        .pending_o    (pending_q),
        .count_o      (count_q),
        .nop_o        (ex1_nop)
    );
endmodule

// File: rtl/lms_checker.sv
module lms_checker #(
    parameter int NUM_REGS = 64,
    parameter int ID_W     = 6,
    parameter int CNT_W    = 7,
    parameter int ZERO_ID  = 0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                miss_valid,
    input logic [ID_W-1:0]     miss_tag,
    input logic                dec_valid,
    input logic                fe_stall,
    input logic                ex1_nop,
    input logic                byp_rs,
    input logic                byp_rt,
    input logic                wb_valid,
    input logic [ID_W-1:0]     wb_tag,
    input logic [NUM_REGS-1:0] pending_q,
    input logic [CNT_W-1:0]    count_q
);
    AST_MISS_SETS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_tag != ID_W'(ZERO_ID)) |=> pending_q[$past(miss_tag)]); // R2

    AST_ZERO_NEVER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_q[ZERO_ID]); // R5

    AST_WB_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> pending_q[wb_tag]); // R7

    AST_RET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !(miss_valid && miss_tag == wb_tag)) |=> !pending_q[$past(wb_tag)]); // R7

    AST_SAME_TAG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && miss_valid && miss_tag == wb_tag) |=> pending_q[$past(wb_tag)]); // R10

    AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        count_q == CNT_W'($countones(pending_q))); // R8

    AST_NOP_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        fe_stall |=> ex1_nop); // R9

    AST_NO_NOP_UNSTALLED: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_stall |=> !ex1_nop); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !(fe_stall || byp_rs || byp_rt)); // R11
endmodule

bind lms_scoreboard lms_checker #(
    .NUM_REGS (NUM_REGS),
    .ID_W     (ID_W),
    .CNT_W    (CNT_W),
    .ZERO_ID  (ZERO_ID)
) u_lms_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_tag   (miss_tag),
    .dec_valid  (dec_valid),
    .fe_stall   (fe_stall),
    .ex1_nop    (ex1_nop),
    .byp_rs     (byp_rs),
    .byp_rt     (byp_rt),
    .wb_valid   (wb_valid),
    .wb_tag     (wb_tag),
    .pending_q  (pending_q),
    .count_q    (count_q)
);

// File: tb/test_lms_scoreboard.sv
`timescale 1ns/1ps
module test_lms_scoreboard;
    localparam int NREG = 64;
    localparam int DW   = 64;
    localparam int LIM  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0, ret_valid = 1'b0, dec_valid = 1'b0;
    logic [5:0]    miss_tag = '0, ret_tag = '0, dec_rs = '0, dec_rt = '0, dec_rd = '0;
    logic [DW-1:0] ret_data = '0;
    logic          fe_stall, ex1_nop, byp_rs, byp_rt, wb_valid;
    logic [5:0]    wb_tag;
    logic [DW-1:0] wb_data;

    int  tests = 0, fails = 0;
    bit  mpend [NREG];
    int  mcnt = 0;
    bit  prev_stall = 1'b0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    lms_scoreboard i_lms_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_tag(miss_tag),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data),
        .dec_valid(dec_valid), .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_rd(dec_rd),
        .fe_stall(fe_stall), .ex1_nop(ex1_nop), .byp_rs(byp_rs), .byp_rt(byp_rt),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data)
    );

    task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_wait(input logic [5:0] id);
        return dec_valid && id != 0 && mpend[id] && !(ret_valid && ret_tag == id);
    endfunction

    function automatic bit m_byp(input logic [5:0] id);
        return dec_valid && id != 0 && mpend[id] && ret_valid && ret_tag == id;
    endfunction

    function automatic bit m_stall();
        return dec_valid && (m_wait(dec_rs) || m_wait(dec_rt) || m_wait(dec_rd) || mcnt >= LIM);
    endfunction

    // one cycle: drive, check at the falling edge, then update the model at the rising edge
    task automatic cyc(input string req, input bit mv, input logic [5:0] mt,
                       input bit rv, input logic [5:0] rt, input bit dv,
                       input logic [5:0] s, input logic [5:0] t, input logic [5:0] d);
        bit es, ewb, clr, nw;
        miss_valid = mv; miss_tag = mt; ret_valid = rv; ret_tag = rt;
        ret_data = {$urandom, $urandom};
        dec_valid = dv; dec_rs = s; dec_rt = t; dec_rd = d;
        @(negedge clk);
        es  = m_stall();
        ewb = rv && mpend[rt];
        chk(req, "fe_stall", DW'(fe_stall), DW'(es));
        chk("R9", "ex1_nop", DW'(ex1_nop), DW'(prev_stall));
        chk(req, "byp_rs", DW'(byp_rs), DW'(m_byp(s)));
        chk(req, "byp_rt", DW'(byp_rt), DW'(m_byp(t)));
        chk("R7", "wb_valid", DW'(wb_valid), DW'(ewb));
        if (ewb) begin
            chk("R7", "wb_tag", DW'(wb_tag), DW'(rt));
            chk("R7", "wb_data", wb_data, ret_data);
        end
        @(posedge clk);
        clr = rv && mpend[rt] && !(mv && mt != 0 && mt == rt);
        nw  = mv && mt != 0 && !mpend[mt];
        if (clr) begin mpend[rt] = 1'b0; mcnt--; end
        if (mv && mt != 0) mpend[mt] = 1'b1;
        if (nw) mcnt++;
        prev_stall = es;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state, decode bundle present while in reset
        dec_valid = 1'b1; dec_rs = 6'd5; dec_rt = 6'd6; dec_rd = 6'd7;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "fe_stall", DW'(fe_stall), '0);
        chk("R1", "ex1_nop", DW'(ex1_nop), '0);
        chk("R1", "byp", DW'({byp_rs, byp_rt}), '0);
        chk("R1", "wb_valid", DW'(wb_valid), '0);
        @(posedge clk); rst_n = 1'b1; #1;

        cyc("R1", 0, 0, 0, 0, 1, 5, 6, 7);           // nothing waiting after reset
        cyc("R2", 1, 5, 0, 0, 1, 5, 0, 0);           // miss on 5 does not stall yet
        cyc("R3", 0, 0, 0, 0, 1, 5, 0, 0);           // rs waits
        cyc("R3", 0, 0, 0, 0, 1, 1, 5, 0);           // rt waits
        cyc("R4", 0, 0, 0, 0, 1, 1, 2, 5);           // rd waits
        cyc("R5", 1, 0, 0, 0, 1, 0, 0, 0);           // zero-register miss dropped
        cyc("R5", 0, 0, 0, 0, 1, 0, 0, 0);           // zero register never stalls
        cyc("R6", 0, 0, 1, 5, 1, 5, 5, 0);           // same-cycle return bypass
        cyc("R7", 0, 0, 0, 0, 1, 5, 0, 5);           // 5 ready again
        cyc("R7", 0, 0, 1, 9, 1, 9, 0, 0);           // return for non-waiting register
        cyc("R11", 1, 8, 0, 0, 0, 0, 0, 0);
        cyc("R11", 0, 0, 1, 8, 0, 8, 8, 0);          // no decode: no stall, no bypass
        cyc("R8", 1, 1, 0, 0, 1, 20, 21, 22);
        cyc("R8", 1, 2, 0, 0, 1, 20, 21, 22);
        cyc("R8", 1, 3, 0, 0, 1, 20, 21, 22);
        cyc("R8", 1, 4, 0, 0, 1, 20, 21, 22);        // count reaches 4 at the edge
        cyc("R8", 0, 0, 0, 0, 1, 20, 21, 22);        // unrelated bundle held
        cyc("R8", 1, 0, 1, 1, 1, 20, 21, 22);        // one completes
        cyc("R8", 0, 0, 0, 0, 1, 20, 21, 22);        // below limit again
        cyc("R10", 1, 7, 1, 2, 1, 0, 0, 0);
        cyc("R10", 1, 7, 1, 7, 1, 30, 0, 0);         // same-tag miss and return
        cyc("R10", 0, 0, 0, 0, 1, 7, 0, 0);          // 7 still waits
        for (int k = 1; k < 10; k++) cyc("R7", 0, 0, 1, 6'(k), 0, 0, 0, 0);

        for (int n = 0; n < 4000; n++) begin
            bit mv, rv, dv;
            logic [5:0] mt, rt, s, t, d;
            mv = ($urandom_range(0, 3) == 0);
            rv = ($urandom_range(0, 2) == 0);
            dv = ($urandom_range(0, 4) != 0);
            mt = 6'($urandom_range(0, 9));
            rt = 6'($urandom_range(0, 9));
            s  = 6'($urandom_range(0, 11));
            t  = 6'($urandom_range(0, 11));
            d  = ($urandom_range(0, 7) == 0) ? 6'($urandom_range(0, 63)) : 6'($urandom_range(0, 11));
            cyc("R3", mv, mt, rv, rt, dv, s, t, d);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule